// File: doc/BRIEF.md
# Software Doorbell and Message Trigger Unit

This block holds one 32-bit doorbell cause register and one 32-bit doorbell enable register for each CPU. A single shared trigger register accepts two kinds of write. A processor can ring a numbered doorbell on any set of CPUs, which acts as an inter-processor interrupt. A bus master can post a message-signalled interrupt, which lands on a fixed default CPU.

Each CPU's handler clears the events it has serviced by writing the complement of the bits it read. Bits written as one are kept and bits written as zero are cleared. For every CPU the block drives two level summaries to the interrupt controller, where they appear as interrupt IDs 0 and 1. The first covers the eight processor doorbells. The second covers the sixteen message doorbells.

Top module: `dbell_trigger_unit`

## Requirements
- R1: After reset every cause register and every enable register reads zero, and every summary output is low.
- R2: A trigger write that is not a message sets cause bit `trig_data[4:0]` in each CPU k for which `trig_data[8+k]` is one. CPUs whose map bit is zero are unchanged.
- R3: A trigger write with `trig_data[11:8]` equal to 4'hF and `trig_data[4]` equal to one is a message. It sets cause bit `trig_data[4:0]` in CPU 0 only, so data 0xF00 | (n+16) sets bit n+16.
- R4: A trigger write with `trig_data[11:8]` equal to 4'hF and `trig_data[4]` equal to zero is not a message. It sets the numbered bit in all four CPUs.
- R5: A cause write with value w leaves that CPU's cause at old & w. Bits written as one are unchanged.
- R6: A cause write of all zeros clears every pending doorbell of that CPU.
- R7: When a trigger write and a cause write to the same CPU fall in the same cycle, the bits set by the trigger end up one, even where the write clears them.
- R8: An enable-register write replaces that CPU's enable register. An enable bit of one enables the doorbell.
- R9: `ipi_irq[k]` is high exactly when some bit of cause[7:0] & enable[7:0] of CPU k is one. Cause bits 8 to 15 never raise a summary.
- R10: `msg_irq[k]` is high exactly when some bit of cause[31:16] & enable[31:16] of CPU k is one.
- R11: A cause or enable write to one CPU leaves the registers of every other CPU unchanged.
- R12: `rd_data` shows CPU `rd_idx`'s cause register when `rd_sel_en` is zero and its enable register when `rd_sel_en` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_we | input | 1 | Write strobe for the shared trigger register |
| trig_data | input | 32 | Trigger data: doorbell number [4:0], CPU map from bit 8, message tag [11:8] |
| cpu_we | input | 1 | Write strobe for a per-CPU register |
| cpu_sel_en | input | 1 | 0 selects the cause register, 1 selects the enable register |
| cpu_idx | input | 2 | Target CPU of a per-CPU write |
| cpu_wdata | input | 32 | Per-CPU write data |
| rd_idx | input | 2 | CPU selected for read |
| rd_sel_en | input | 1 | 0 reads cause, 1 reads enable |
| rd_data | output | 32 | Read data |
| ipi_irq | output | 4 | Per-CPU processor-doorbell summary |
| msg_irq | output | 4 | Per-CPU message-doorbell summary |

## Verification
The hardest case to reach from the ports is a trigger write and a clearing cause write landing on the same CPU in the same clock. The bench drives both strobes in one cycle. First it preloads bits that the write should clear, then it rings a bit that the same write also clears, and checks that only the rung bit survives. A second hard case is the decode boundary of the shared trigger register. A map of all ones in [11:8] decodes as an all-CPU broadcast when the number is below 16, and as a message to CPU 0 when the number is 16 or above. Both cases are rung back to back.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int DB_W       = 32;
  localparam int NUM_W      = 5;
  localparam int MAP_LSB    = 8;
  localparam int IPI_N      = 8;
  localparam int MSG_LSB    = 16;
  localparam int MSG_N      = 16;
  localparam int TAG_LSB    = 8;
  localparam int TAG_W      = 4;
  localparam logic [TAG_W-1:0] MSG_TAG = 4'hF;
  localparam int MSG_CPU    = 0;
  typedef logic [DB_W-1:0] db_word_t;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                    trig_we,
  input  db_word_t                trig_data,
  output logic [NUM_CPU-1:0][DB_W-1:0] set_bits
);
  logic     is_msg;
  db_word_t onehot;

  always_comb begin
    is_msg = (trig_data[TAG_LSB +: TAG_W] == MSG_TAG) && trig_data[NUM_W-1];
    onehot = db_word_t'(1) << trig_data[NUM_W-1:0];
  end

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_tgt
    logic hit;
    always_comb begin
      if (is_msg) hit = (k == MSG_CPU);
      else        hit = trig_data[MAP_LSB + k];
      set_bits[k] = (trig_we && hit) ? onehot : '0;
    end
  end
endmodule

// File: rtl/dbell_bank.sv
module dbell_bank
  import dbell_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  db_word_t set_bits,
  input  logic     cause_we,
  input  logic     en_we,
  input  db_word_t wdata,
  output db_word_t cause_q,
  output db_word_t en_q,
  output logic     ipi_irq,
  output logic     msg_irq
);
  db_word_t cause_d;
  logic     cause_ce;

  always_comb begin
    cause_d = cause_q;
    if (cause_we) cause_d = cause_q & wdata;
    cause_d  = cause_d | set_bits;
    cause_ce = cause_we || (|set_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_ce) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= wdata;
  end

  always_comb begin
    ipi_irq = |(cause_q[IPI_N-1:0] & en_q[IPI_N-1:0]);
    msg_irq = |(cause_q[MSG_LSB +: MSG_N] & en_q[MSG_LSB +: MSG_N]);
  end
endmodule

// File: rtl/dbell_trigger_unit.sv
module dbell_trigger_unit
  import dbell_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [31:0]       trig_data,
  input  logic              cpu_we,
  input  logic              cpu_sel_en,
  input  logic [CPU_IW-1:0] cpu_idx,
  input  logic [31:0]       cpu_wdata,
  input  logic [CPU_IW-1:0] rd_idx,
  input  logic              rd_sel_en,
  output logic [31:0]       rd_data,
  output logic [NUM_CPU-1:0] ipi_irq,
  output logic [NUM_CPU-1:0] msg_irq
);
  logic [1:0] rst_sync;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_q = rst_sync[1];

  logic [NUM_CPU-1:0][DB_W-1:0] set_bits;
  logic [NUM_CPU-1:0][DB_W-1:0] cause_all;
  logic [NUM_CPU-1:0][DB_W-1:0] en_all;

  dbell_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .trig_we  (trig_we),
    .trig_data(trig_data),
    .set_bits (set_bits)
  );

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
    logic sel;
    assign sel = cpu_we && (cpu_idx == CPU_IW'(k));
    dbell_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n_q),
      .set_bits(set_bits[k]),
      .cause_we(sel && !cpu_sel_en),
      .en_we   (sel && cpu_sel_en),
      .wdata   (cpu_wdata),
      .cause_q (cause_all[k]),
      .en_q    (en_all[k]),
      .ipi_irq (ipi_irq[k]),
      .msg_irq (msg_irq[k])
    );
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < NUM_CPU)
      rd_data = rd_sel_en ? en_all[rd_idx] : cause_all[rd_idx];
  end
endmodule

// File: rtl/dbell_chk.sv
module dbell_chk #(
  parameter int NUM_CPU = 4,
  parameter int CPU_IW  = 2
) (
  input logic                  clk,
  input logic                  rst_n_q,
  input logic                  trig_we,
  input logic [31:0]           trig_data,
  input logic                  cpu_we,
  input logic                  cpu_sel_en,
  input logic [CPU_IW-1:0]     cpu_idx,
  input logic [31:0]           cpu_wdata,
  input logic [NUM_CPU-1:0]    ipi_irq,
  input logic [NUM_CPU-1:0]    msg_irq,
  input logic [NUM_CPU*32-1:0] cause_flat,
  input logic [NUM_CPU*32-1:0] en_flat
);
  logic is_msg;
  assign is_msg = (trig_data[11:8] == 4'hF) && trig_data[4];

  AST_SET_REACHES_CPU0: assert property (@(posedge clk) disable iff (!rst_n_q)
    trig_we && (is_msg || trig_data[8]) |=> cause_flat[$past(trig_data[4:0])]); // R7

  AST_MSG_SKIPS_CPU1: assert property (@(posedge clk) disable iff (!rst_n_q)
    trig_we && is_msg && !cpu_we |=> $stable(cause_flat[63:32])); // R3

  AST_ZERO_WRITE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n_q)
    cpu_we && !cpu_sel_en && (cpu_idx == '0) && (cpu_wdata == '0) && !trig_we
    |=> (cause_flat[31:0] == '0)); // R6

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_q)
    !(cpu_we && cpu_sel_en) |=> $stable(en_flat)); // R8

  AST_IPI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    ipi_irq[0] |-> (|en_flat[7:0]) && (|cause_flat[7:0])); // R9

  AST_MSG_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_q)
    msg_irq[0] |-> (|cause_flat[31:16]) && (|en_flat[31:16])); // R10
endmodule

bind dbell_trigger_unit dbell_chk #(.NUM_CPU(NUM_CPU), .CPU_IW(CPU_IW)) u_chk (
  .clk       (clk),
  .rst_n_q   (rst_n_q),
  .trig_we   (trig_we),
  .trig_data (trig_data),
  .cpu_we    (cpu_we),
  .cpu_sel_en(cpu_sel_en),
  .cpu_idx   (cpu_idx),
  .cpu_wdata (cpu_wdata),
  .ipi_irq   (ipi_irq),
  .msg_irq   (msg_irq),
  .cause_flat(cause_all),
  .en_flat   (en_all)
);

// File: tb/sim_dbell_trigger_unit.sv
`timescale 1ns/1ps
module sim_dbell_trigger_unit;
  localparam int NC = 4;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_we;
  logic [31:0] trig_data;
  logic        cpu_we, cpu_sel_en;
  logic [1:0]  cpu_idx, rd_idx;
  logic [31:0] cpu_wdata;
  logic        rd_sel_en;
  logic [31:0] rd_data;
  logic [NC-1:0] ipi_irq, msg_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_cause [NC];
  logic [31:0] m_en    [NC];

  always #5 clk = ~clk;

  dbell_trigger_unit #(.NUM_CPU(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_data(trig_data),
    .cpu_we(cpu_we), .cpu_sel_en(cpu_sel_en), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .rd_idx(rd_idx), .rd_sel_en(rd_sel_en),
    .rd_data(rd_data), .ipi_irq(ipi_irq), .msg_irq(msg_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_set(input logic [31:0] d);
    if (d[11:8] == 4'hF && d[4]) m_cause[0][d[4:0]] = 1'b1;
    else for (int k = 0; k < NC; k++) if (d[8+k]) m_cause[k][d[4:0]] = 1'b1;
  endtask

  task automatic model_wr(input int i, input logic en, input logic [31:0] w);
    if (en) m_en[i] = w;
    else    m_cause[i] = m_cause[i] & w;
  endtask

  task automatic check_state(input string tag);
    for (int k = 0; k < NC; k++) begin
      rd_idx = 2'(k); rd_sel_en = 1'b0; #1;
      chk({tag, " cause"}, rd_data, m_cause[k]);
      rd_sel_en = 1'b1; #1;
      chk({tag, " R12 enable"}, rd_data, m_en[k]);
      chk("R9 ipi", 32'(ipi_irq[k]), 32'(|(m_cause[k][7:0] & m_en[k][7:0])));
      chk("R10 msg", 32'(msg_irq[k]), 32'(|(m_cause[k][31:16] & m_en[k][31:16])));
    end
  endtask

  task automatic trig(input logic [31:0] d);
    @(negedge clk); trig_we = 1'b1; trig_data = d;
    @(negedge clk); trig_we = 1'b0; trig_data = '0;
    model_set(d);
  endtask

  task automatic cpu_wr(input int i, input logic en, input logic [31:0] w);
    @(negedge clk); cpu_we = 1'b1; cpu_idx = 2'(i); cpu_sel_en = en; cpu_wdata = w;
    @(negedge clk); cpu_we = 1'b0; cpu_wdata = '0;
    model_wr(i, en, w);
  endtask

  task automatic t_reset;
    for (int k = 0; k < NC; k++) begin m_cause[k] = '0; m_en[k] = '0; end
    check_state("R1");
  endtask

  task automatic t_ipi;
    trig(32'h0000_0503);           // CPUs 0 and 2, doorbell 3
    check_state("R2");
    for (int k = 0; k < NC; k++) cpu_wr(k, 1'b1, 32'hFFFF_00FF);
    check_state("R8");
    trig(32'h0000_0A0B);           // doorbell 11 on CPUs 1 and 3: no summary
    check_state("R9");
  endtask

  task automatic t_msg;
    for (int n = 0; n < 16; n += 5) trig(32'h0000_0F00 | 32'(n + 16));
    check_state("R3");
    trig(32'h0000_0F06);           // number below 16: broadcast
    check_state("R4");
  endtask

  task automatic t_clear;
    cpu_wr(0, 1'b0, ~32'h0000_0008);
    check_state("R5");
    cpu_wr(2, 1'b0, 32'hFFFF_FFFF);
    check_state("R5 ones");
    cpu_wr(1, 1'b0, 32'h0);
    check_state("R6");
    cpu_wr(3, 1'b1, 32'h0000_0040);
    check_state("R11");
  endtask

  task automatic t_priority;
    trig(32'h0000_0102);
    trig(32'h0000_0105);
    @(negedge clk);
    trig_we = 1'b1; trig_data = 32'h0000_0105;
    cpu_we = 1'b1; cpu_idx = 2'd0; cpu_sel_en = 1'b0; cpu_wdata = 32'h0;
    @(negedge clk);
    trig_we = 1'b0; cpu_we = 1'b0;
    model_wr(0, 1'b0, 32'h0); model_set(32'h0000_0105);
    rd_idx = 2'd0; rd_sel_en = 1'b0; #1;
    chk("R7 set wins", rd_data, 32'h0000_0020);
    check_state("R7");
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig_we = 1'b0; trig_data = '0; cpu_we = 1'b0;
    cpu_sel_en = 1'b0; cpu_idx = '0; cpu_wdata = '0; rd_idx = '0; rd_sel_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_ipi;
    t_msg;
    t_clear;
    t_priority;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule